// File: doc/BRIEF.md
# Counted-Loop Branch Resolver

This block resolves the control-flow outcome of a count-controlled loop instruction. It takes a 4-bit condition selector, five condition flags, a 32-bit loop counter, the instruction address and a 16-bit signed displacement. In a single clock cycle it works out the new counter value, whether the counter must be written back, whether the branch is taken, and the next program counter. It then registers these results.

A true condition ends the loop at once, and the counter is not touched. A false condition decrements only the low 16 bits of the counter. The branch back is then skipped if those 16 bits have wrapped to all ones. Instruction decode and the register file sit outside the block. The core feeds it operands and writes `count_o` back when `count_we_o` is high.

Top module: `loop_branch_unit`

## Requirements
- R1: While `rst_n` is low, all outputs are zero.
- R2: When the selected condition is true, `count_we_o` and `taken_o` are 0, `count_o` equals the input counter, and `next_pc_o` is the instruction address plus 4.
- R3: When the selected condition is false, `count_we_o` is 1, `count_o[15:0]` is the input low half minus one (modulo 2^16), and `count_o[31:16]` equals the input upper half, with no borrow into it.
- R4: When the condition is false and the decremented low half equals 0xFFFF, `taken_o` is 0 and `next_pc_o` is the instruction address plus 4, while `count_we_o` stays 1.
- R5: When the condition is false and the decremented low half is not 0xFFFF, `taken_o` is 1 and `next_pc_o` is the instruction address plus 2 plus the sign-extended displacement.
- R6: Selector codes are 0 always true, 1 always false, 2 C=0 and Z=0, 3 C=1 or Z=1, 4 C=0, 5 C=1, 6 Z=0, 7 Z=1, 8 V=0, 9 V=1, 10 N=0, 11 N=1, 12 N==V, 13 N!=V, 14 Z=0 and N==V, 15 Z=1 or N!=V. Flags enter as `flags_i` = {X, N, Z, V, C}, with C in bit 0 and X in bit 4.
- R7: The X flag (`flags_i[4]`) has no effect on any output.
- R8: Outputs reflect the inputs sampled at the previous rising clock edge. They do not change before that edge.
- R9: Displacements with bit 15 set move the target backwards, and the address sum wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_sel_i | input | 4 | Condition selector |
| flags_i | input | 5 | Flags {X, N, Z, V, C} |
| count_i | input | 32 | Loop counter value |
| pc_i | input | 32 | Address of the loop instruction |
| disp_i | input | 16 | Signed branch displacement |
| count_o | output | 32 | Updated counter value |
| count_we_o | output | 1 | Counter write-back enable |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 32 | Next program counter |

## Verification
The bench targets these corner cases:
- A low half of zero. This must wrap to 0xFFFF and exit. A design that tested for zero before decrementing would loop one time too many. A design that borrowed into the upper half would corrupt `count_o[31:16]`.
- A counter of 1. This must still branch.
- The largest negative displacement, and a target sum that wraps past 2^32. These expose zero-extension and a wrong base offset.
- Every selector code with opposing flag patterns, which catches swapped encodings.
- An X-only flag pattern, which shows whether a design wrongly feeds X into the condition.

// File: rtl/loop_pkg.sv
`timescale 1ns/1ps
package loop_pkg;
    localparam int CNT_W  = 32;
    localparam int ADDR_W = 32;
    localparam int LOW_W  = 16;
    localparam int DISP_W = 16;
    localparam int FLAG_W = 5;

    // flag positions inside the flag vector
    localparam int FLAG_C = 0;
    localparam int FLAG_V = 1;
    localparam int FLAG_Z = 2;
    localparam int FLAG_N = 3;
    localparam int FLAG_X = 4;

    typedef enum logic [3:0] {
        SEL_TRUE  = 4'd0,  SEL_FALSE = 4'd1,
        SEL_HI    = 4'd2,  SEL_LS    = 4'd3,
        SEL_CC    = 4'd4,  SEL_CS    = 4'd5,
        SEL_NE    = 4'd6,  SEL_EQ    = 4'd7,
        SEL_VC    = 4'd8,  SEL_VS    = 4'd9,
        SEL_PL    = 4'd10, SEL_MI    = 4'd11,
        SEL_GE    = 4'd12, SEL_LT    = 4'd13,
        SEL_GT    = 4'd14, SEL_LE    = 4'd15
    } cond_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic              we;
        logic              taken;
        logic [ADDR_W-1:0] pc;
    } loop_out_t;
endpackage

// File: rtl/loop_cond_eval.sv
`timescale 1ns/1ps
module loop_cond_eval
    import loop_pkg::*;
(
    input  logic [3:0] sel_i,
    input  logic       n_i,
    input  logic       z_i,
    input  logic       v_i,
    input  logic       c_i,
    output logic       true_o
);
    logic sign_ok;

    always_comb begin
        sign_ok = (n_i == v_i);
        unique case (cond_sel_e'(sel_i))
            SEL_TRUE:  true_o = 1'b1;
            SEL_FALSE: true_o = 1'b0;
            SEL_HI:    true_o = !c_i && !z_i;
            SEL_LS:    true_o = c_i || z_i;
            SEL_CC:    true_o = !c_i;
            SEL_CS:    true_o = c_i;
            SEL_NE:    true_o = !z_i;
            SEL_EQ:    true_o = z_i;
            SEL_VC:    true_o = !v_i;
            SEL_VS:    true_o = v_i;
            SEL_PL:    true_o = !n_i;
            SEL_MI:    true_o = n_i;
            SEL_GE:    true_o = sign_ok;
            SEL_LT:    true_o = !sign_ok;
            SEL_GT:    true_o = !z_i && sign_ok;
            SEL_LE:    true_o = z_i || !sign_ok;
            default:   true_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/loop_count_step.sv
`timescale 1ns/1ps
module loop_count_step #(
    parameter int CNT_W = 32,
    parameter int LOW_W = 16
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic             hold_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);
    logic [LOW_W-1:0] low_dec;

    always_comb begin
        low_dec = count_i[LOW_W-1:0] - LOW_W'(1);
        wrap_o  = (low_dec == {LOW_W{1'b1}});
        if (hold_i) begin
            count_o = count_i;
        end else begin
            count_o = {count_i[CNT_W-1:LOW_W], low_dec};
        end
    end
endmodule

// File: rtl/loop_target_calc.sv
`timescale 1ns/1ps
module loop_target_calc #(
    parameter int ADDR_W   = 32,
    parameter int DISP_W   = 16,
    parameter int DISP_OFS = 2,
    parameter int INSN_LEN = 4
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [ADDR_W-1:0] fall_o,
    output logic [ADDR_W-1:0] branch_o
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;

    always_comb begin
        disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
        fall_o   = pc_i + ADDR_W'(INSN_LEN);
        branch_o = pc_i + ADDR_W'(DISP_OFS) + disp_ext;
    end
endmodule

// File: rtl/loop_branch_unit.sv
`timescale 1ns/1ps
module loop_branch_unit
    import loop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cond_sel_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              count_we_o,
    output logic              taken_o,
    output logic [ADDR_W-1:0] next_pc_o
);
    logic              cond_true;
    logic              wrap;
    logic [CNT_W-1:0]  count_next;
    logic [ADDR_W-1:0] fall_pc;
    logic [ADDR_W-1:0] branch_pc;
    logic              unused_x;
    loop_out_t         res_d, res_q;

    assign unused_x = flags_i[FLAG_X];

    loop_cond_eval i_cond (
        .sel_i  (cond_sel_i),
        .n_i    (flags_i[FLAG_N]),
        .z_i    (flags_i[FLAG_Z]),
        .v_i    (flags_i[FLAG_V]),
        .c_i    (flags_i[FLAG_C]),
        .true_o (cond_true)
    );

    loop_count_step #(.CNT_W(CNT_W), .LOW_W(LOW_W)) i_step (
        .count_i (count_i),
        .hold_i  (cond_true),
        .count_o (count_next),
        .wrap_o  (wrap)
    );

    loop_target_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) i_tgt (
        .pc_i     (pc_i),
        .disp_i   (disp_i),
        .fall_o   (fall_pc),
        .branch_o (branch_pc)
    );

    always_comb begin
        res_d.count = count_next;
        res_d.we    = !cond_true;
        res_d.taken = !cond_true && !wrap;
        res_d.pc    = res_d.taken ? branch_pc : fall_pc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign count_o    = res_q.count;
    assign count_we_o = res_q.we;
    assign taken_o    = res_q.taken;
    assign next_pc_o  = res_q.pc;
endmodule

// File: rtl/loop_branch_unit_chk.sv
`timescale 1ns/1ps
module loop_branch_unit_chk
    import loop_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        cond_sel_i,
    input logic [FLAG_W-1:0] flags_i,
    input logic [CNT_W-1:0]  count_i,
    input logic [ADDR_W-1:0] pc_i,
    input logic [DISP_W-1:0] disp_i,
    input logic [CNT_W-1:0]  count_o,
    input logic              count_we_o,
    input logic              taken_o,
    input logic [ADDR_W-1:0] next_pc_o
);
    logic primed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    AST_TAKEN_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> count_we_o); // R5

    AST_EXIT_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (count_we_o && count_o[LOW_W-1:0] == {LOW_W{1'b1}}) |-> !taken_o); // R4

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> count_o[CNT_W-1:LOW_W] == $past(count_i[CNT_W-1:LOW_W])); // R3

    AST_LOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && count_we_o) |->
            count_o[LOW_W-1:0] == $past(count_i[LOW_W-1:0]) - LOW_W'(1)); // R3

    AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !count_we_o) |-> (count_o == $past(count_i) && !taken_o)); // R2

    AST_FALL_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !taken_o) |-> next_pc_o == $past(pc_i) + ADDR_W'(4)); // R2

    AST_SEL_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(cond_sel_i) == 4'd0) |-> !count_we_o); // R6

    AST_SEL_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(cond_sel_i) == 4'd1) |-> count_we_o); // R6
endmodule

bind loop_branch_unit loop_branch_unit_chk i_chk (.*);

// File: tb/test_loop_branch_unit.sv
`timescale 1ns/1ps
module test_loop_branch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cond_sel_i = '0;
    logic [4:0]  flags_i = '0;
    logic [31:0] count_i = '0;
    logic [31:0] pc_i = '0;
    logic [15:0] disp_i = '0;
    logic [31:0] count_o;
    logic        count_we_o;
    logic        taken_o;
    logic [31:0] next_pc_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    loop_branch_unit i_loop_branch_unit (.*);

    typedef struct packed {
        logic [3:0]  sel;
        logic [4:0]  flg;
        logic [31:0] cnt;
        logic [31:0] pc;
        logic [15:0] disp;
        logic [31:0] e_cnt;
        logic        e_we;
        logic        e_tk;
        logic [31:0] e_pc;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{4'd0,  5'b00000, 32'h12340005, 32'h00001000, 16'h0010, 32'h12340005, 1'b0, 1'b0, 32'h00001004}, // R2
        '{4'd1,  5'b00000, 32'h12340005, 32'h00001000, 16'h0010, 32'h12340004, 1'b1, 1'b1, 32'h00001012}, // R5
        '{4'd1,  5'b00000, 32'hABCD0000, 32'h00002000, 16'hFFF0, 32'hABCDFFFF, 1'b1, 1'b0, 32'h00002004}, // R4
        '{4'd1,  5'b00000, 32'h00000001, 32'h00002000, 16'hFFF0, 32'h00000000, 1'b1, 1'b1, 32'h00001FF2}, // R9
        '{4'd7,  5'b00100, 32'h00000007, 32'h00003000, 16'h0100, 32'h00000007, 1'b0, 1'b0, 32'h00003004}, // R6
        '{4'd7,  5'b00000, 32'h00000007, 32'h00003000, 16'h0100, 32'h00000006, 1'b1, 1'b1, 32'h00003102}, // R6
        '{4'd12, 5'b01000, 32'hFFFF0002, 32'h00004000, 16'h7FFE, 32'hFFFF0001, 1'b1, 1'b1, 32'h0000C000}, // R6
        '{4'd12, 5'b01010, 32'hFFFF0002, 32'h00004000, 16'h7FFE, 32'hFFFF0002, 1'b0, 1'b0, 32'h00004004}, // R6
        '{4'd1,  5'b00000, 32'h00000010, 32'h00010000, 16'h8000, 32'h0000000F, 1'b1, 1'b1, 32'h00008002}, // R9
        '{4'd1,  5'b00000, 32'h00000005, 32'hFFFFFFFE, 16'h0004, 32'h00000004, 1'b1, 1'b1, 32'h00000004}, // R9
        '{4'd1,  5'b00000, 32'hFFFF0000, 32'h00005000, 16'h0040, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h00005004}  // R3
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] s, input logic [4:0] f, input logic [31:0] c,
                         input logic [31:0] p, input logic [15:0] d);
        @(negedge clk);
        cond_sel_i = s; flags_i = f; count_i = c; pc_i = p; disp_i = d;
        @(negedge clk);
    endtask

    // condition truth taken from the selector list of R6; flags {X,N,Z,V,C}
    function automatic bit cond_model(input logic [3:0] s, input logic [4:0] f);
        bit n, z, v, c;
        n = f[3]; z = f[2]; v = f[1]; c = f[0];
        case (s)
            4'd0: return 1'b1;       4'd1: return 1'b0;
            4'd2: return !c && !z;   4'd3: return c || z;
            4'd4: return !c;         4'd5: return c;
            4'd6: return !z;         4'd7: return z;
            4'd8: return !v;         4'd9: return v;
            4'd10: return !n;        4'd11: return n;
            4'd12: return n == v;    4'd13: return n != v;
            4'd14: return !z && (n == v);
            default: return z || (n != v);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cond_sel_i = 4'd1; count_i = 32'h5; pc_i = 32'h100; disp_i = 16'h20;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(count_o == 0 && !count_we_o && !taken_o && next_pc_o == 0, "R1 reset",
              {count_o[29:0], count_we_o, taken_o}, 32'd0);
        check(next_pc_o == 0, "R1 reset pc", next_pc_o, 32'd0);
        rst_n = 1'b1;

        // table of vectors
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].sel, VEC[i].flg, VEC[i].cnt, VEC[i].pc, VEC[i].disp);
            check(count_o == VEC[i].e_cnt, $sformatf("R3 vec%0d count", i), count_o, VEC[i].e_cnt);
            check(count_we_o == VEC[i].e_we, $sformatf("R2 vec%0d we", i), 32'(count_we_o), 32'(VEC[i].e_we));
            check(taken_o == VEC[i].e_tk, $sformatf("R5 vec%0d taken", i), 32'(taken_o), 32'(VEC[i].e_tk));
            check(next_pc_o == VEC[i].e_pc, $sformatf("R5 vec%0d pc", i), next_pc_o, VEC[i].e_pc);
        end

        // R6: every selector against several flag patterns
        for (int s = 0; s < 16; s++) begin
            for (int k = 0; k < 4; k++) begin
                logic [4:0] f;
                bit t;
                f = (k == 0) ? 5'b00000 : (k == 1) ? 5'b01111 : (k == 2) ? 5'b00101 : 5'b01010;
                t = cond_model(4'(s), f);
                drive(4'(s), f, 32'h00000009, 32'h00006000, 16'h0020);
                check(count_we_o == !t, $sformatf("R6 sel%0d flags%b we", s, f), 32'(count_we_o), 32'(!t));
                check(next_pc_o == (t ? 32'h6004 : 32'h6022), $sformatf("R6 sel%0d flags%b pc", s, f),
                      next_pc_o, t ? 32'h6004 : 32'h6022);
            end
        end

        // R7: X alone must not change any selector's outcome
        for (int s = 0; s < 16; s++) begin
            bit t;
            t = cond_model(4'(s), 5'b00000);
            drive(4'(s), 5'b10000, 32'h00030002, 32'h00007000, 16'h0010);
            check(count_we_o == !t && taken_o == !t, $sformatf("R7 sel%0d X only", s),
                  32'(count_we_o), 32'(!t));
            check(count_o == (t ? 32'h00030002 : 32'h00030001), $sformatf("R7 sel%0d count", s),
                  count_o, t ? 32'h00030002 : 32'h00030001);
        end

        // R8: output holds until the next rising edge
        drive(4'd0, 5'b0, 32'h11, 32'h8000, 16'h0);
        @(negedge clk);
        cond_sel_i = 4'd1; count_i = 32'h22; pc_i = 32'h9000; disp_i = 16'h10;
        #1;
        check(next_pc_o == 32'h8004 && !count_we_o, "R8 before edge", next_pc_o, 32'h8004);
        @(negedge clk);
        check(next_pc_o == 32'h9012 && count_o == 32'h21, "R8 after edge", next_pc_o, 32'h9012);

        // R1: asynchronous reset mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(count_o == 0 && next_pc_o == 0 && !taken_o && !count_we_o, "R1 reset again",
              next_pc_o, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule